// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Unit

This block is the hazard and bypass controller for a five-stage in-order integer pipeline. The pipeline decides its branches in the decode stage. The unit compares the source register numbers of the instruction in decode with the destination register numbers held in the execute, memory and writeback stages. From these comparisons it does four things:

- It picks the bypass sources for the ALU operands.
- It supplies a bypassed operand to the decode-stage zero test.
- It requests a stall when a value cannot be bypassed in time.
- It squashes the single instruction fetched behind a taken branch or jump, and gives the fetch unit the new program counter.

The ALU operand selects are worked out while the consumer sits in decode. They are held in a register and take effect when the consumer reaches execute. A stall freezes the program counter and the fetch/decode register and sends a bubble into execute. A flush replaces the fetch/decode contents with a no-op.

Top module: `hazard_fwd_unit`

## Requirements
- R1: The two 2-bit operand selects (`ex_fwd_a` for the first source, `ex_fwd_b` for the second) change one clock after the decode inputs that cause them. They read 01 (memory-stage result) when the used source matched the execute-stage destination. They read 10 (writeback-stage result) when it matched the memory-stage destination. Otherwise they read 00 (register file).
- R2: When the execute-stage and memory-stage destinations both match a source, the younger producer wins and the select reads 01.
- R3: Register 0 never produces a bypass. A stage whose write-enable is low never produces a bypass.
- R4: `stall` rises in the same cycle when the execute stage holds a load whose destination equals a source that decode uses. In the next cycle both selects read 00 (bubble), whatever decode presented.
- R5: The operand of the decode-stage zero test is taken from the memory-stage result on a memory-stage match. Failing that, it comes from the writeback value on a writeback match. Otherwise it comes from the register file read.
- R6: Branch kind (`id_br_kind`) 1 means branch-if-zero and kind 2 means branch-if-nonzero. When the condition holds and no stall is raised, `flush` is 1 and `redirect_pc` equals `id_target`. When the condition fails, `flush` is 0.
- R7: Kind 3 (jump to an immediate target) always flushes, with `redirect_pc` = `id_target`. Kind 4 (jump through a register) always flushes, with `redirect_pc` = the bypassed first-source value. Kind 0 never flushes.
- R8: A branch of kind 1, 2 or 4 stalls, and does not flush, when its first source matches the execute-stage destination. It also stalls, and does not flush, when its first source matches a load in the memory stage.
- R9: After reset both selects read 00, and `stall` and `flush` are 0 for an idle decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_rs1 | input | REG_AW | First source register in decode (also the branch operand) |
| id_rs2 | input | REG_AW | Second source register in decode |
| id_use_rs1 | input | 1 | Decode instruction reads the first source as an ALU operand |
| id_use_rs2 | input | 1 | Decode instruction reads the second source as an ALU operand |
| id_br_kind | input | 3 | 0 none, 1 branch-if-zero, 2 branch-if-nonzero, 3 immediate jump, 4 register jump |
| id_rs1_val | input | DATA_W | Register file read of the first source |
| id_target | input | DATA_W | Target address computed in decode |
| ex_rd | input | REG_AW | Execute-stage destination |
| ex_we | input | 1 | Execute-stage register write-enable |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | REG_AW | Memory-stage destination |
| mem_we | input | 1 | Memory-stage register write-enable |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_alu_val | input | DATA_W | Memory-stage ALU result |
| wb_rd | input | REG_AW | Writeback-stage destination |
| wb_we | input | 1 | Writeback-stage register write-enable |
| wb_val | input | DATA_W | Writeback-stage result |
| stall | output | 1 | Hold PC and fetch/decode register, bubble into execute |
| flush | output | 1 | Replace fetch/decode contents with a no-op |
| redirect_pc | output | DATA_W | New fetch address, valid while flush is 1 |
| ex_fwd_a | output | 2 | Registered first ALU operand select |
| ex_fwd_b | output | 2 | Registered second ALU operand select |

## Verification
The hardest situation to reach is a decode branch whose operand is in flight in two places at once. In that case the zero test must favour the memory-stage value over a conflicting writeback value, and the wrong choice flips the branch outcome. The bench presents the same destination in the memory and writeback stages with one value zero and the other nonzero, then checks `flush` under both branch senses. A second hard case is a stall that coincides with a live bypass match. The bench drives a load-use pair while the other source also matches. It then confirms that the registered selects come out as a bubble rather than the bypass codes.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_MEM = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;

  typedef enum logic [2:0] {
    BR_NONE = 3'd0,
    BR_EQZ  = 3'd1,
    BR_NEZ  = 3'd2,
    BR_JMP  = 3'd3,
    BR_JREG = 3'd4
  } br_kind_e;

  typedef struct packed {
    logic ex;
    logic mem;
    logic wb;
  } hit_t;
endpackage

// File: rtl/hzd_src_match.sv
module hzd_src_match #(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] rs,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_we,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  output hzd_pkg::hit_t     hit
);
  logic nz;
  assign nz      = (rs != '0);
  assign hit.ex  = nz && ex_we  && (ex_rd  == rs);
  assign hit.mem = nz && mem_we && (mem_rd == rs);
  assign hit.wb  = nz && wb_we  && (wb_rd  == rs);
endmodule

// File: rtl/hzd_branch_unit.sv
module hzd_branch_unit #(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        kind,
  input  hzd_pkg::hit_t     hit,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] mem_val,
  input  logic [DATA_W-1:0] wb_val,
  input  logic [DATA_W-1:0] target,
  output logic              reads_reg,
  output logic              taken,
  output logic [DATA_W-1:0] redirect
);
  import hzd_pkg::*;
  br_kind_e          k;
  logic [DATA_W-1:0] opval;
  logic              is_zero;

  assign k = br_kind_e'(kind);

  always_comb begin
    if (hit.mem)     opval = mem_val;
    else if (hit.wb) opval = wb_val;
    else             opval = rf_val;
  end

  assign is_zero = (opval == '0);

  always_comb begin
    taken     = 1'b0;
    reads_reg = 1'b0;
    redirect  = target;
    case (k)
      BR_EQZ:  begin taken = is_zero;  reads_reg = 1'b1; end
      BR_NEZ:  begin taken = !is_zero; reads_reg = 1'b1; end
      BR_JMP:  taken = 1'b1;
      BR_JREG: begin taken = 1'b1; reads_reg = 1'b1; redirect = opval; end
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/hzd_fwd_reg.sv
module hzd_fwd_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       bubble,
  input  logic [1:0] sel_a_d,
  input  logic [1:0] sel_b_d,
  output logic [1:0] sel_a_q,
  output logic [1:0] sel_b_q
);
  always_ff @(posedge clk) begin
    if (rst || bubble) begin
      sel_a_q <= 2'b00;
      sel_b_q <= 2'b00;
    end else begin
      sel_a_q <= sel_a_d;
      sel_b_q <= sel_b_d;
    end
  end

  // R4: a bubble cycle leaves register-file selects in execute
  p_bubble_clears_r4: assert property (@(posedge clk) disable iff (rst)
    bubble |=> (sel_a_q == 2'b00 && sel_b_q == 2'b00));
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
  parameter int REG_AW = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_use_rs1,
  input  logic              id_use_rs2,
  input  logic [2:0]        id_br_kind,
  input  logic [DATA_W-1:0] id_rs1_val,
  input  logic [DATA_W-1:0] id_target,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              ex_we,
  input  logic              ex_load,
  input  logic [REG_AW-1:0] mem_rd,
  input  logic              mem_we,
  input  logic              mem_load,
  input  logic [DATA_W-1:0] mem_alu_val,
  input  logic [REG_AW-1:0] wb_rd,
  input  logic              wb_we,
  input  logic [DATA_W-1:0] wb_val,
  output logic              stall,
  output logic              flush,
  output logic [DATA_W-1:0] redirect_pc,
  output logic [1:0]        ex_fwd_a,
  output logic [1:0]        ex_fwd_b
);
  import hzd_pkg::*;
  localparam int NSRC = 2;

  logic [REG_AW-1:0] src    [NSRC];
  logic              src_use[NSRC];
  hit_t              hit    [NSRC];
  logic [1:0]        sel_d  [NSRC];
  logic              lu_hit [NSRC];

  assign src[0]     = id_rs1;
  assign src[1]     = id_rs2;
  assign src_use[0] = id_use_rs1;
  assign src_use[1] = id_use_rs2;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hzd_src_match #(.REG_AW(REG_AW)) u_match (
      .rs(src[g]), .ex_rd(ex_rd), .ex_we(ex_we),
      .mem_rd(mem_rd), .mem_we(mem_we),
      .wb_rd(wb_rd), .wb_we(wb_we), .hit(hit[g])
    );
    always_comb begin
      if (!src_use[g])      sel_d[g] = FWD_RF;
      else if (hit[g].ex)   sel_d[g] = FWD_MEM;
      else if (hit[g].mem)  sel_d[g] = FWD_WB;
      else                  sel_d[g] = FWD_RF;
    end
    assign lu_hit[g] = src_use[g] && hit[g].ex && ex_load;
  end

  logic              br_reads, br_taken, load_use, br_wait;
  logic [DATA_W-1:0] br_redirect;

  hzd_branch_unit #(.DATA_W(DATA_W)) u_branch (
    .kind(id_br_kind), .hit(hit[0]), .rf_val(id_rs1_val),
    .mem_val(mem_alu_val), .wb_val(wb_val), .target(id_target),
    .reads_reg(br_reads), .taken(br_taken), .redirect(br_redirect)
  );

  assign load_use    = lu_hit[0] || lu_hit[1];
  assign br_wait     = br_reads && (hit[0].ex || (hit[0].mem && mem_load));
  assign stall       = load_use || br_wait;
  assign flush       = br_taken && !stall;
  assign redirect_pc = br_redirect;

  hzd_fwd_reg u_fwd_reg (
    .clk(clk), .rst(rst), .bubble(stall),
    .sel_a_d(sel_d[0]), .sel_b_d(sel_d[1]),
    .sel_a_q(ex_fwd_a), .sel_b_q(ex_fwd_b)
  );

  // R4: load in execute feeding a used source must stall
  p_load_use_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (ex_load && ex_we && ex_rd != '0 && id_use_rs2 && id_rs2 == ex_rd) |-> stall);
  // R3: register 0 is never bypassed
  p_r0_no_fwd_r3: assert property (@(posedge clk) disable iff (rst)
    (id_rs1 == '0 && !stall) |=> ex_fwd_a == 2'b00);
  // R7: no control transfer kind, no flush
  p_no_kind_no_flush_r7: assert property (@(posedge clk) disable iff (rst)
    flush |-> id_br_kind != 3'd0);
  // R1: select codes stay in the legal set
  p_sel_legal_r1: assert property (@(posedge clk) disable iff (rst)
    ex_fwd_a != 2'b11 && ex_fwd_b != 2'b11);
  // R8: a branch waiting on execute never flushes
  p_br_wait_no_flush_r8: assert property (@(posedge clk) disable iff (rst)
    (id_br_kind == 3'd1 && ex_we && ex_rd == id_rs1 && id_rs1 != '0) |-> (stall && !flush));
endmodule

// File: tb/hazard_fwd_unit_tb_top.sv
module hazard_fwd_unit_tb_top;
  localparam int AW = 5;
  localparam int DW = 32;

  logic clk = 0, rst = 1;
  logic [AW-1:0] id_rs1, id_rs2, ex_rd, mem_rd, wb_rd;
  logic id_use_rs1, id_use_rs2, ex_we, ex_load, mem_we, mem_load, wb_we;
  logic [2:0] id_br_kind;
  logic [DW-1:0] id_rs1_val, id_target, mem_alu_val, wb_val, redirect_pc;
  logic stall, flush;
  logic [1:0] ex_fwd_a, ex_fwd_b;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hazard_fwd_unit #(.REG_AW(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2), .id_br_kind(id_br_kind),
    .id_rs1_val(id_rs1_val), .id_target(id_target),
    .ex_rd(ex_rd), .ex_we(ex_we), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_load(mem_load), .mem_alu_val(mem_alu_val),
    .wb_rd(wb_rd), .wb_we(wb_we), .wb_val(wb_val),
    .stall(stall), .flush(flush), .redirect_pc(redirect_pc),
    .ex_fwd_a(ex_fwd_a), .ex_fwd_b(ex_fwd_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    id_rs1 = 0; id_rs2 = 0; id_use_rs1 = 0; id_use_rs2 = 0; id_br_kind = 0;
    id_rs1_val = 32'h1; id_target = 32'h0;
    ex_rd = 0; ex_we = 0; ex_load = 0;
    mem_rd = 0; mem_we = 0; mem_load = 0; mem_alu_val = 0;
    wb_rd = 0; wb_we = 0; wb_val = 0;
  endtask

  // apply at negedge, settle for comb checks
  task automatic apply();
    #2;
  endtask

  // advance through posedge, land mid low phase
  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    idle(); rst = 1; tick(); tick(); rst = 0; apply();
    chk("R9 sel_a", ex_fwd_a, 0); chk("R9 sel_b", ex_fwd_b, 0);
    chk("R9 stall", stall, 0);    chk("R9 flush", flush, 0);
  endtask

  task automatic t_basic_fwd();
    idle(); id_use_rs1 = 1; id_use_rs2 = 1; id_rs1 = 3; id_rs2 = 7;
    ex_rd = 3; ex_we = 1; mem_rd = 7; mem_we = 1; apply();
    chk("R1 no stall", stall, 0);
    tick();
    chk("R1 a from mem stage", ex_fwd_a, 2'b01);
    chk("R1 b from wb stage", ex_fwd_b, 2'b10);
    idle(); id_use_rs1 = 1; id_rs1 = 9; wb_rd = 9; wb_we = 1; apply(); tick();
    chk("R1 wb match needs no bypass", ex_fwd_a, 2'b00);
  endtask

  task automatic t_priority();
    idle(); id_use_rs2 = 1; id_rs2 = 5; ex_rd = 5; ex_we = 1; mem_rd = 5; mem_we = 1;
    apply(); tick();
    chk("R2 younger wins", ex_fwd_b, 2'b01);
  endtask

  task automatic t_qualify();
    idle(); id_use_rs1 = 1; id_rs1 = 6; ex_rd = 6; ex_we = 0; mem_rd = 6; mem_we = 0;
    apply(); tick();
    chk("R3 we low no bypass", ex_fwd_a, 2'b00);
    idle(); id_use_rs1 = 1; id_use_rs2 = 1; id_rs1 = 0; id_rs2 = 0;
    ex_rd = 0; ex_we = 1; mem_rd = 0; mem_we = 1; apply(); tick();
    chk("R3 r0 a", ex_fwd_a, 2'b00); chk("R3 r0 b", ex_fwd_b, 2'b00);
  endtask

  task automatic t_load_use();
    idle(); id_use_rs1 = 1; id_use_rs2 = 1; id_rs1 = 8; id_rs2 = 4;
    ex_rd = 4; ex_we = 1; ex_load = 1; mem_rd = 8; mem_we = 1; apply();
    chk("R4 stall", stall, 1); chk("R4 no flush", flush, 0);
    tick();
    chk("R4 bubble a", ex_fwd_a, 2'b00); chk("R4 bubble b", ex_fwd_b, 2'b00);
    idle(); id_rs2 = 4; id_use_rs2 = 0; ex_rd = 4; ex_we = 1; ex_load = 1; apply();
    chk("R4 unused source no stall", stall, 0);
    tick();
  endtask

  task automatic t_branch_cond();
    idle(); id_br_kind = 1; id_rs1 = 2; id_rs1_val = 0; id_target = 32'h40; apply();
    chk("R6 beqz flush", flush, 1); chk("R6 beqz target", redirect_pc, 32'h40);
    id_br_kind = 2; apply();
    chk("R6 bnez on zero", flush, 0);
    id_rs1_val = 32'h5; apply();
    chk("R6 bnez on nonzero", flush, 1);
    tick();
  endtask

  task automatic t_branch_fwd();
    idle(); id_br_kind = 1; id_rs1 = 11; id_rs1_val = 32'h9;
    mem_rd = 11; mem_we = 1; mem_alu_val = 0; wb_rd = 11; wb_we = 1; wb_val = 32'h5;
    apply();
    chk("R5 mem value first beqz", flush, 1);
    id_br_kind = 2; apply();
    chk("R5 mem value first bnez", flush, 0);
    mem_we = 0; wb_val = 0; id_br_kind = 1; apply();
    chk("R5 wb value beqz", flush, 1);
    tick();
  endtask

  task automatic t_branch_wait();
    idle(); id_br_kind = 1; id_rs1 = 12; id_rs1_val = 0; ex_rd = 12; ex_we = 1; apply();
    chk("R8 ex dep stall", stall, 1); chk("R8 ex dep no flush", flush, 0);
    idle(); id_br_kind = 2; id_rs1 = 13; mem_rd = 13; mem_we = 1; mem_load = 1;
    mem_alu_val = 32'h7; apply();
    chk("R8 mem load stall", stall, 1); chk("R8 mem load no flush", flush, 0);
    tick();
  endtask

  task automatic t_jumps();
    idle(); id_br_kind = 3; id_target = 32'h1234; apply();
    chk("R7 jump flush", flush, 1); chk("R7 jump target", redirect_pc, 32'h1234);
    idle(); id_br_kind = 4; id_rs1 = 14; id_rs1_val = 32'h99;
    wb_rd = 14; wb_we = 1; wb_val = 32'hABC0; id_target = 32'h1; apply();
    chk("R7 jreg flush", flush, 1); chk("R7 jreg target", redirect_pc, 32'hABC0);
    idle(); id_rs1_val = 0; apply();
    chk("R7 none no flush", flush, 0);
    tick();
  endtask

  initial begin
    idle();
    @(negedge clk);
    t_reset();
    t_basic_fwd();
    t_priority();
    t_qualify();
    t_load_use();
    t_branch_cond();
    t_branch_fwd();
    t_branch_wait();
    t_jumps();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule